// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block models a small non-volatile word memory reached over a three-wire serial link: a chip select, a serial clock and a data input. Replies come back on one data output. A separate write-enable pin arms every programming command. The array holds 64 words of 16 bits. One command reads any number of words in a row. Other commands store one word, store up to four words within an aligned group of four, or fill the whole array with one value. The remaining two commands set a protection limit and freeze that limit for good.

Every input is sampled on the system clock `clk`. A serial clock rise counts when `sclk` is seen low in one `clk` cycle and high in the next while `cs` is high. A programming command takes effect when chip select falls after its last bit. A fixed programming time then follows, counted in `clk` cycles. During that time the block takes no serial traffic and reports busy on `sdo` whenever `cs` is high.

Top module: `mw_eeprom_slave`

## Requirements
- R1: Zeros received while `cs` is high and no command is open are skipped. The first 1 is the start bit. It is followed by a 2-bit opcode, then a 6-bit address, then data words of 16 bits. All fields are sent MSB first and sampled on rising `sclk`.
- R2: Opcode 10 reads. After the last address bit, `sdo` shows bit 15 of the addressed word and moves one bit lower on each further rise. Words follow back to back, and the address increments and wraps from 63 to 0.
- R3: Opcode 01 with exactly one data word stores that word at the address only when the address is below the protection limit.
- R4: Opcode 11 with one to four data words stores word k at the address whose low two bits are (A1..A0 + k) mod 4, with the upper bits fixed. Nothing is stored if any of those words is at or above the limit, or if more than four words arrive.
- R5: Opcode 00 with address bits A5..A4 = 01 and one data word writes that word to all 64 locations, but only while the limit is 64 or more.
- R6: Opcode 00 with A5..A4 = 10 and one data word loads data bits 6..0 into the protection limit. Words at addresses greater than or equal to the limit are protected. The limit is 64 after reset, and the command is ignored once the lock is set.
- R7: Opcode 00 with A5..A4 = 11 and no data sets the lock, which stays set until reset.
- R8: A programming command is ignored unless `wen` is high at the start bit, at every later sampled rise, and when `cs` falls.
- R9: A programming command runs only if `cs` falls after the last required bit and before any further rise. A short or over-long frame is dropped.
- R10: A command that runs makes the block busy for PROG_CYCLES clocks, and all serial traffic is ignored during that time. While `cs` is high, `sdo` is 0 when busy and 1 when ready, until the next start bit.
- R11: `sdo` is 0 whenever `cs` is low and after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data input |
| wen | input | 1 | Write-enable pin |
| sdo | output | 1 | Serial data output and busy/ready status |

## Verification
The bench runs a page write that starts near the top of its group and must wrap to the group's first word. A design that carried into A2 would overwrite a word in the next group. It also sends a page that crosses the limit by one word and checks that the words below the limit stay unchanged. A design that filtered word by word instead of rejecting the whole page would store those words. A read that crosses address 63 catches a counter that saturates or runs into a neighbouring bit. Frames cut one bit short or one bit long, a write with `wen` low, a command sent while busy, and a limit change tried after lock each show up as a changed word if the design accepted them. Random writes checked against a bench model cover the general path.

// File: rtl/mw_eeprom_slave.sv
module mw_eeprom_slave #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int PROG_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  input  logic wen,
  output logic sdo
);
  localparam int WORDS = 1 << AW;
  localparam int HL = AW + 2;
  localparam int HCW = $clog2(HL);
  localparam int DCW = $clog2(DW);
  localparam int BCW = $clog2(PROG_CYCLES + 1);

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] pbuf [4];
  logic sclk_q, cs_q, started, hdone, at_end, wok, ovf, st, locked;
  logic [AW:0] prot;
  logic [HL-1:0] hdr;
  logic [HCW-1:0] hcnt;
  logic [DCW-1:0] dcnt;
  logic [DW-1:0] dat, rsh;
  logic [AW-1:0] ptr;
  logic [2:0] wcnt;
  logic [BCW-1:0] bcnt;
  logic [AW-1:0] pg_a [4];
  logic pg_hit;

  logic busy, rise, cs_fall, reading, done, go;
  logic do_wr, do_pg, do_wall, do_prot, do_lock;
  logic [HL-1:0] hdr_n;
  logic [DW-1:0] dat_n;
  logic [1:0] op, ext;
  logic [AW-1:0] addr, ptr_n;

  assign busy    = bcnt != '0;
  assign rise    = cs && sclk && !sclk_q && !busy;
  assign cs_fall = cs_q && !cs;
  assign hdr_n   = {hdr[HL-2:0], sdi};
  assign dat_n   = {dat[DW-2:0], sdi};
  assign op      = hdr[HL-1 -: 2];
  assign ext     = hdr[AW-1 -: 2];
  assign addr    = hdr[AW-1:0];
  assign ptr_n   = ptr + 1'b1;
  assign reading = started && hdone && op == 2'b10;
  assign done    = cs_fall && started && hdone && at_end && wok && wen && !busy;

  always_comb begin
    pg_hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pg_a[k] = {addr[AW-1:2], 2'(addr[1:0] + 2'(k))};
      if (3'(k) < wcnt && {1'b0, pg_a[k]} >= prot) pg_hit = 1'b1;
    end
  end

  assign do_wr   = done && op == 2'b01 && wcnt == 3'd1 && {1'b0, addr} < prot;
  assign do_pg   = done && op == 2'b11 && wcnt != 3'd0 && !ovf && !pg_hit;
  assign do_wall = done && op == 2'b00 && ext == 2'b01 && wcnt == 3'd1 && prot >= (AW+1)'(WORDS);
  assign do_prot = done && op == 2'b00 && ext == 2'b10 && wcnt == 3'd1 && !locked;
  assign do_lock = done && op == 2'b00 && ext == 2'b11 && wcnt == 3'd0 && !locked;
  assign go      = do_wr || do_pg || do_wall || do_prot || do_lock;

  assign sdo = cs && (st ? !busy : (reading && rsh[DW-1]));

  always_ff @(posedge clk) begin
    if (do_wall) for (int i = 0; i < WORDS; i++) mem[i] <= pbuf[0];
    if (do_wr) mem[addr] <= pbuf[0];
    if (do_pg) for (int k = 0; k < 4; k++) if (3'(k) < wcnt) mem[pg_a[k]] <= pbuf[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0; cs_q <= 1'b0; started <= 1'b0; hdone <= 1'b0;
      at_end <= 1'b0; wok <= 1'b0; ovf <= 1'b0; st <= 1'b0; locked <= 1'b0;
      prot <= (AW+1)'(WORDS); hdr <= '0; hcnt <= '0; dcnt <= '0;
      dat <= '0; rsh <= '0; ptr <= '0; wcnt <= '0; bcnt <= '0;
      for (int k = 0; k < 4; k++) pbuf[k] <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs;
      if (!cs) started <= 1'b0;
      if (rise) begin
        if (!started) begin
          if (sdi) begin
            started <= 1'b1; hdone <= 1'b0; hcnt <= '0; dcnt <= '0;
            wcnt <= '0; ovf <= 1'b0; at_end <= 1'b0; wok <= wen; st <= 1'b0;
          end
        end else begin
          if (!wen) wok <= 1'b0;
          if (!hdone) begin
            hdr  <= hdr_n;
            hcnt <= hcnt + 1'b1;
            at_end <= hcnt == HCW'(HL-1);
            if (hcnt == HCW'(HL-1)) begin
              hdone <= 1'b1;
              rsh   <= mem[hdr_n[AW-1:0]];
              ptr   <= hdr_n[AW-1:0];
            end
          end else if (reading) begin
            dcnt <= dcnt + 1'b1;
            if (dcnt == DCW'(DW-1)) begin
              rsh <= mem[ptr_n];
              ptr <= ptr_n;
            end else begin
              rsh <= rsh << 1;
            end
          end else begin
            dat  <= dat_n;
            dcnt <= dcnt + 1'b1;
            at_end <= dcnt == DCW'(DW-1);
            if (dcnt == DCW'(DW-1)) begin
              if (wcnt == 3'd4) ovf <= 1'b1;
              else begin
                pbuf[wcnt[1:0]] <= dat_n;
                wcnt <= wcnt + 1'b1;
              end
            end
          end
        end
      end
      if (do_prot) prot <= pbuf[0][AW:0];
      if (do_lock) locked <= 1'b1;
      if (go) begin
        bcnt <= BCW'(PROG_CYCLES);
        st   <= 1'b1;
      end else if (busy) begin
        bcnt <= bcnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mw_eeprom_slave_chk.sv
module mw_eeprom_slave_chk #(
  parameter int AW = 6
) (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sdo,
  input logic busy,
  input logic started,
  input logic locked,
  input logic [AW:0] prot
);
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !sdo); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked); // R7
  AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(prot)); // R6
  AST_BUSY_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> ($past(!cs) && $past(cs, 2))); // R10
  AST_DEAF_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !started); // R10
endmodule

bind mw_eeprom_slave mw_eeprom_slave_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sdo(sdo), .busy(busy),
  .started(started), .locked(locked), .prot(prot)
);

// File: tb/mw_eeprom_slave_bench.sv
module mw_eeprom_slave_bench;
  localparam int PROG = 400;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, sdi = 1'b0, wen = 1'b1;
  logic sdo;
  int n_cmp = 0, n_bad = 0;
  logic [15:0] mdl [64];
  logic [15:0] pd [4];
  int lim = 64;
  bit lck = 0;

  always #2.5 clk = ~clk;

  mw_eeprom_slave #(.PROG_CYCLES(PROG)) u_mw_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .wen(wen), .sdo(sdo)
  );

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic bitx(logic b);
    @(negedge clk) sdi = b; sclk = 1'b0;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendv(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bitx(v[i]);
  endtask

  task automatic cs_up;
    @(negedge clk) cs = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_dn;
    @(negedge clk) cs = 1'b0; sclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic settle;
    repeat (PROG + 10) @(negedge clk);
  endtask

  // tweak: -1 drops the final bit, +1 adds one extra bit
  task automatic cmd(logic [1:0] op, logic [5:0] a, int nw, int tweak);
    cs_up;
    bitx(1'b1);
    sendv(16'(op), 2);
    sendv(16'(a), 6);
    for (int w = 0; w < nw; w++)
      for (int b = 15; b >= 0; b--)
        if (!(tweak < 0 && w == nw - 1 && b == 0)) bitx(pd[w][b]);
    if (tweak > 0) bitx(1'b0);
    cs_dn;
  endtask

  task automatic rd(logic [5:0] a, int n, string r);
    logic [15:0] v;
    cs_up;
    bitx(1'b1);
    sendv(16'(2'b10), 2);
    sendv(16'(a), 6);
    for (int w = 0; w < n; w++) begin
      for (int b = 15; b >= 0; b--) begin
        @(negedge clk) sclk = 1'b0;
        repeat (2) @(negedge clk);
        v[b] = sdo;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
      end
      chk(r, v, mdl[6'(a + 6'(w))]);
    end
    cs_dn;
  endtask

  function automatic void m_wr(int a, logic [15:0] d);
    if (a < lim) mdl[a] = d;
  endfunction

  function automatic void m_pg(int a, int n);
    bit hit = 0;
    for (int k = 0; k < n; k++) if (((a & ~3) | ((a + k) & 3)) >= lim) hit = 1;
    if (!hit) for (int k = 0; k < n; k++) mdl[(a & ~3) | ((a + k) & 3)] = pd[k];
  endfunction

  task automatic wr(int a, logic [15:0] d);
    pd[0] = d;
    cmd(2'b01, 6'(a), 1, 0);
    m_wr(a, d);
    settle;
  endtask

  initial begin
    int cnt;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    chk("R11 reset sdo", 16'(sdo), 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R5 fill all, R10 busy then ready
    pd[0] = 16'h1234;
    cmd(2'b00, 6'b01_0000, 1, 0);
    for (int i = 0; i < 64; i++) mdl[i] = 16'h1234;
    cs_up;
    chk("R10 busy low", 16'(sdo), 16'd0);
    cnt = 0;
    while (!sdo && cnt < PROG + 50) begin @(negedge clk); cnt++; end
    chk("R10 ready high", 16'(sdo), 16'd1);
    cs_dn;
    chk("R11 cs low", 16'(sdo), 16'd0);
    rd(6'd0, 2, "R5 fill");

    // R3 single write, R2 rollover read
    wr(63, 16'hBEEF);
    wr(0, 16'h0F0F);
    rd(6'd62, 4, "R2 rollover");
    wr(5, 16'hA5A5);
    rd(6'd5, 1, "R3 write");

    // R4 page wrap: 14,15,12
    pd[0] = 16'h1111; pd[1] = 16'h2222; pd[2] = 16'h3333;
    cmd(2'b11, 6'd14, 3, 0); m_pg(14, 3); settle;
    rd(6'd12, 4, "R4 page wrap");

    // R8 write enable low
    wen = 1'b0; pd[0] = 16'hDEAD; cmd(2'b01, 6'd7, 1, 0); settle; wen = 1'b1;
    rd(6'd7, 1, "R8 wen low");

    // R9 short and long frames
    pd[0] = 16'h7777; cmd(2'b01, 6'd8, 1, -1); settle;
    rd(6'd8, 1, "R9 short frame");
    cmd(2'b01, 6'd8, 1, 1); settle;
    rd(6'd8, 1, "R9 long frame");

    // R10 command during busy ignored
    pd[0] = 16'h9999; cmd(2'b01, 6'd9, 1, 0); m_wr(9, 16'h9999);
    pd[0] = 16'h4444; cmd(2'b01, 6'd10, 1, 0); settle;
    rd(6'd9, 2, "R10 ignore busy");

    // R1 leading zeros skipped
    cs_up; bitx(1'b0); bitx(1'b0); bitx(1'b1);
    sendv(16'(2'b01), 2); sendv(16'd11, 6); sendv(16'hC0DE, 16); cs_dn;
    m_wr(11, 16'hC0DE); settle;
    rd(6'd11, 1, "R1 leading zeros");

    // R6 limit 38
    pd[0] = 16'd38; cmd(2'b00, 6'b10_0000, 1, 0); lim = 38; settle;
    wr(45, 16'h5555);
    wr(37, 16'h6666);
    rd(6'd37, 1, "R6 below limit");
    rd(6'd45, 1, "R6 protected");

    // R4 page touching 38 rejected, page 32..35 accepted
    pd[0] = 16'hAAAA; pd[1] = 16'hBBBB; pd[2] = 16'hCCCC; pd[3] = 16'hDDDD;
    cmd(2'b11, 6'd36, 3, 0); m_pg(36, 3); settle;
    rd(6'd36, 3, "R4 page reject");
    cmd(2'b11, 6'd32, 4, 0); m_pg(32, 4); settle;
    rd(6'd32, 4, "R4 full page");

    // R5 fill with protection active ignored
    pd[0] = 16'hFFFF; cmd(2'b00, 6'b01_0000, 1, 0); settle;
    rd(6'd20, 1, "R5 fill blocked");

    // R7 lock then limit change ignored
    cmd(2'b00, 6'b11_0000, 0, 0); lck = 1; settle;
    pd[0] = 16'd64; cmd(2'b00, 6'b10_0000, 1, 0); settle;
    wr(45, 16'h1357);
    rd(6'd45, 1, "R7 locked limit");
    wr(20, 16'h2468);
    rd(6'd20, 1, "R7 write below");

    // random writes against the model
    for (int i = 0; i < 30; i++) wr(int'($urandom % 64), 16'($urandom));
    rd(6'($urandom % 64), 64, "R3 random");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule